// File: doc/BRIEF.md
# Converter Control Front End with Serial Target Port

This block is the digital control side of a four-input, one-output data converter. It listens on a two-wire serial bus (I2C) as a target. It samples the clock and data lines with the system clock and recognises START and STOP conditions. It answers only to its own seven-bit address. That address is the fixed prefix `1001` followed by three strap pins. The first byte written after a matching write address loads the control register.

The control register produces four things. One flag enables the analog output and the oscillator. A two-bit field picks how the four inputs are grouped. An auto-advance flag lets the channel step on its own. A two-bit field names the channel. A channel sequencer keeps the active channel legal for the current grouping. When auto-advance is on, the sequencer steps the channel on each single-cycle conversion-done pulse and wraps from the highest legal channel back to channel 0.

The converter, the analog output stage and the read data path lie outside the block. Only the control outputs and the open-drain SDA pull-down are produced.

Top module: `cvf_frontend`

## Requirements
- R1: The block acknowledges (sda_oe = 1 while SCL is high during the ninth clock) an address byte whose upper seven bits equal `1001` followed by addr_strap[2:1:0]. The SDA pull-down changes only while SCL is low.
- R2: An address byte with a different prefix or strap value is not acknowledged and leaves every control output unchanged. Clocked bytes that follow no START condition are likewise not acknowledged and have no effect.
- R3: The first data byte after a write address (bit 0 = 0) loads the control register. Later data bytes in the same transfer are acknowledged but do not change any output.
- R4: Control bit 6 drives both aout_en and osc_en. When it is 0, both outputs are 0, which means the analog output is high-impedance and the oscillator is stopped.
- R5: Control bits 5:4 appear on input_mode. Mode 00 allows channels 0 to 3, 01 allows 0 to 2, 10 allows 0 to 2, and 11 allows 0 to 1.
- R6: Control bits 7 and 3 are reserved. They are held at 0, and writing them has no effect on any output.
- R7: When control bits 1:0 are written, active_channel becomes that value. If the value exceeds the highest legal channel of the newly written mode, active_channel becomes that highest legal channel instead.
- R8: With control bit 2 (auto-advance) set, a one-cycle conv_done pulse raises active_channel by one on the next clock edge.
- R9: With auto-advance set and active_channel at the highest legal channel, conv_done sets it to 0.
- R10: With auto-advance clear, conv_done leaves active_channel unchanged.
- R11: After reset, all control outputs and sda_oe are 0.
- R12: For a read address (bit 0 = 1), the address is acknowledged, and SDA is then left released for the rest of the transfer.
- R13: A repeated START ends the current transfer. The next byte is then taken as an address, and the first data byte after a new matching write address loads the control register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_strap | input | 3 | Strap bits forming the low three address bits |
| conv_done | input | 1 | One-cycle pulse marking a completed conversion |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| aout_en | output | 1 | Analog output enable; 0 leaves the output high-impedance |
| osc_en | output | 1 | Oscillator enable |
| input_mode | output | 2 | Input grouping field |
| active_channel | output | 2 | Channel currently selected for conversion |

## Verification
The checker tests several behaviours on every cycle: the active channel never exceeds the limit of the current mode; each conversion pulse steps the channel, wraps it, or leaves it alone according to the auto-advance flag; the channel and mode hold still when no write or pulse arrives; and the SDA pull-down moves only while the synchronised SCL is low. Address matching belongs to the bench's bus transfers, and so do the rule that only the first data byte counts, the handling of the reserved bits, repeated START, read-direction release and the bytes sent without a START. Those scenarios are needed because each rule depends on a whole sequence of bus events, not on a relation between neighbouring cycles.

// File: rtl/cvf_pkg.sv
package cvf_pkg;

  localparam int CTRL_W   = 8;
  localparam int CHAN_W   = 2;
  localparam int MODE_W   = 2;

  // control byte field positions (decoded by the sequencer and the bench)
  localparam int AOE_BIT  = 6;
  localparam int MODE_LSB = 4;
  localparam int AUTO_BIT = 2;
  localparam int CHAN_LSB = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_HOLD,
    ST_ACK,
    ST_SKIP
  } tgt_state_e;

  // highest legal channel for a given input grouping
  function automatic logic [CHAN_W-1:0] top_chan(input logic [MODE_W-1:0] mode);
    logic [CHAN_W-1:0] lim;
    case (mode)
      2'b00:   lim = 2'd3;
      2'b01:   lim = 2'd2;
      2'b10:   lim = 2'd2;
      default: lim = 2'd1;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/cvf_line_sync.sv
module cvf_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/cvf_target_fsm.sv
module cvf_target_fsm
  import cvf_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        addr_strap,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [CTRL_W-1:0] wr_byte
);

  localparam int CNT_W = $clog2(CTRL_W);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CTRL_W-1:0] shreg_q, shreg_d;
  logic              is_addr_q, is_addr_d;
  logic              wr_dir_q, wr_dir_d;
  logic              first_q, first_d;
  logic              stb_d;
  logic [6:0]        my_addr;

  assign my_addr = {ADDR_PREFIX, addr_strap};

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    shreg_d   = shreg_q;
    is_addr_d = is_addr_q;
    wr_dir_d  = wr_dir_q;
    first_d   = first_q;
    stb_d     = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      first_d = 1'b0;
    end else if (start_det) begin
      state_d   = ST_RX;
      cnt_d     = '0;
      is_addr_d = 1'b1;
      first_d   = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[CTRL_W-2:0], sda_s};
            cnt_d   = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CTRL_W - 1)) state_d = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (scl_fall) begin
            if (is_addr_q) begin
              if (shreg_q[7:1] == my_addr) begin
                state_d  = ST_ACK;
                wr_dir_d = ~shreg_q[0];
                first_d  = ~shreg_q[0];
              end else begin
                state_d = ST_SKIP;
              end
            end else begin
              state_d = ST_ACK;
              if (first_q) begin
                stb_d   = 1'b1;
                first_d = 1'b0;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            is_addr_d = 1'b0;
            cnt_d     = '0;
            state_d   = wr_dir_q ? ST_RX : ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      is_addr_q <= 1'b0;
      wr_dir_q  <= 1'b0;
      first_q   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_byte   <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      shreg_q   <= shreg_d;
      is_addr_q <= is_addr_d;
      wr_dir_q  <= wr_dir_d;
      first_q   <= first_d;
      sda_oe    <= (state_d == ST_ACK);
      wr_stb    <= stb_d;
      if (stb_d) wr_byte <= shreg_q;
    end
  end

endmodule

// File: rtl/cvf_ctrl_seq.sv
module cvf_ctrl_seq
  import cvf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CTRL_W-1:0] wr_byte,
  input  logic              conv_done,
  output logic              aout_en,
  output logic              auto_flag,
  output logic [MODE_W-1:0] input_mode,
  output logic [CHAN_W-1:0] active_channel
);

  logic              aoe_q, aoe_d;
  logic              auto_q, auto_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [MODE_W-1:0] wr_mode;
  logic [CHAN_W-1:0] wr_chan;
  logic [CHAN_W-1:0] wr_lim;
  logic [CHAN_W-1:0] cur_lim;
  logic              unused_rsv;

  assign wr_mode    = wr_byte[MODE_LSB +: MODE_W];
  assign wr_chan    = wr_byte[CHAN_LSB +: CHAN_W];
  assign wr_lim     = top_chan(wr_mode);
  assign cur_lim    = top_chan(mode_q);
  assign unused_rsv = ^{wr_byte[7], wr_byte[3]};

  always_comb begin
    aoe_d  = aoe_q;
    auto_d = auto_q;
    mode_d = mode_q;
    chan_d = chan_q;
    if (wr_stb) begin
      aoe_d  = wr_byte[AOE_BIT];
      auto_d = wr_byte[AUTO_BIT];
      mode_d = wr_mode;
      chan_d = (wr_chan > wr_lim) ? wr_lim : wr_chan;
    end else if (conv_done && auto_q) begin
      chan_d = (chan_q >= cur_lim) ? '0 : chan_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aoe_q  <= 1'b0;
      auto_q <= 1'b0;
      mode_q <= '0;
      chan_q <= '0;
    end else begin
      aoe_q  <= aoe_d;
      auto_q <= auto_d;
      mode_q <= mode_d;
      chan_q <= chan_d;
    end
  end

  assign aout_en        = aoe_q;
  assign auto_flag      = auto_q;
  assign input_mode     = mode_q;
  assign active_channel = chan_q;

endmodule

// File: rtl/cvf_frontend.sv
module cvf_frontend
  import cvf_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b1001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_strap,
  input  logic       conv_done,
  output logic       sda_oe,
  output logic       aout_en,
  output logic       osc_en,
  output logic [1:0] input_mode,
  output logic [1:0] active_channel
);

  logic [1:0]        rst_pipe;
  logic              rst_n_int;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_stb;
  logic [CTRL_W-1:0] wr_byte;
  logic              auto_flag;
  logic              aoe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  cvf_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cvf_target_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .addr_strap (addr_strap),
    .sda_oe     (sda_oe),
    .wr_stb     (wr_stb),
    .wr_byte    (wr_byte)
  );

  cvf_ctrl_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .wr_stb         (wr_stb),
    .wr_byte        (wr_byte),
    .conv_done      (conv_done),
    .aout_en        (aoe),
    .auto_flag      (auto_flag),
    .input_mode     (input_mode),
    .active_channel (active_channel)
  );

  assign aout_en = aoe;
  assign osc_en  = aoe;

endmodule

// File: rtl/cvf_frontend_chk.sv
module cvf_frontend_chk
  import cvf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       conv_done,
  input logic       ctrl_wr,
  input logic       auto_flag,
  input logic       scl_s,
  input logic       sda_oe,
  input logic [1:0] input_mode,
  input logic [1:0] active_channel
);

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_channel <= top_chan(input_mode)); // R7

  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && auto_flag && !ctrl_wr && active_channel < top_chan(input_mode))
    |=> active_channel == $past(active_channel) + 2'd1); // R8

  AST_AUTO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && auto_flag && !ctrl_wr && active_channel == top_chan(input_mode))
    |=> active_channel == 2'd0); // R9

  AST_NO_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !auto_flag && !ctrl_wr) |=> $stable(active_channel)); // R10

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !ctrl_wr) |=> ($stable(active_channel) && $stable(input_mode))); // R3

  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R1

  AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s); // R1

endmodule

bind cvf_frontend cvf_frontend_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .conv_done      (conv_done),
  .ctrl_wr        (wr_stb),
  .auto_flag      (auto_flag),
  .scl_s          (scl_s),
  .sda_oe         (sda_oe),
  .input_mode     (input_mode),
  .active_channel (active_channel)
);

// File: tb/cvf_frontend_tb.sv
module cvf_frontend_tb;

  localparam int Q = 8;               // clocks per quarter bit
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b1001, STRAP, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b1001, STRAP, 1'b1};

  // {ctrl byte, 3'b0, expected {aout, mode[1:0], chan[1:0]}}
  localparam logic [15:0] VEC [8] = '{
    {8'h00, 3'b000, 5'b0_00_00},
    {8'h43, 3'b000, 5'b1_00_11},
    {8'h13, 3'b000, 5'b0_01_10},
    {8'h73, 3'b000, 5'b1_11_01},
    {8'h62, 3'b000, 5'b1_10_10},
    {8'hFF, 3'b000, 5'b1_11_01},
    {8'h21, 3'b000, 5'b0_10_01},
    {8'h88, 3'b000, 5'b0_00_00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       conv_done = 1'b0;
  logic       sda_oe, aout_en, osc_en;
  logic [1:0] input_mode, active_channel;
  logic [2:0] strap = STRAP;
  logic       sda_bus;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  cvf_frontend u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl),
    .sda_i          (sda_bus),
    .addr_strap     (strap),
    .conv_done      (conv_done),
    .sda_oe         (sda_oe),
    .aout_en        (aout_en),
    .osc_en         (osc_en),
    .input_mode     (input_mode),
    .active_channel (active_channel)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [4:0] exp);
    chk(req, {3'b0, aout_en, input_mode, active_channel}, {3'b0, exp});
    chk({req, " osc"}, {7'b0, osc_en}, {7'b0, exp[4]});
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b0; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b1; wq();
  endtask

  // sends a byte, returns the ack seen and whether sda_oe showed up during data bits
  task automatic bus_byte(input logic [7:0] b, output logic ack, output logic oe_seen);
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl = 1'b1;   wq();
      oe_seen = oe_seen | sda_oe;
      wq();
      scl = 1'b0;   wq();
    end
    sda_m = 1'b1; wq();
    scl = 1'b1;   wq();
    ack = sda_oe;
    wq();
    scl = 1'b0;   wq();
  endtask

  task automatic write_ctrl(input logic [7:0] c, output logic a0, output logic a1);
    logic oe;
    bus_start();
    bus_byte(ADDR_W, a0, oe);
    bus_byte(c, a1, oe);
    bus_stop();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_done();
    conv_done = 1'b1; @(negedge clk);
    conv_done = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic a0, a1, oe;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk_out("R11 reset outputs", 5'b0);
    chk("R11 reset sda_oe", {7'b0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      write_ctrl(VEC[v][15:8], a0, a1);
      chk("R1 addr ack", {7'b0, a0}, 8'h01);
      chk("R3 data ack", {7'b0, a1}, 8'h01);
      chk_out($sformatf("R3 R4 R5 R6 R7 vec %0d", v), VEC[v][4:0]);
    end

    // R2 wrong strap and wrong prefix
    write_ctrl(8'h42, a0, a1);
    chk_out("R3 setup", 5'b1_00_10);
    bus_start();
    bus_byte({4'b1001, 3'b111, 1'b0}, a0, oe);
    chk("R2 strap mismatch no ack", {7'b0, a0}, 8'h00);
    bus_byte(8'h31, a1, oe);
    chk("R2 no ack after mismatch", {7'b0, a1}, 8'h00);
    bus_stop();
    repeat (4) @(negedge clk);
    chk_out("R2 outputs kept strap", 5'b1_00_10);
    bus_start();
    bus_byte({4'b0001, STRAP, 1'b0}, a0, oe);
    chk("R2 prefix mismatch no ack", {7'b0, a0}, 8'h00);
    bus_byte(8'h31, a1, oe);
    bus_stop();
    repeat (4) @(negedge clk);
    chk_out("R2 outputs kept prefix", 5'b1_00_10);

    // R2 bytes with no START
    bus_byte(ADDR_W, a0, oe);
    chk("R2 no start no ack", {7'b0, a0}, 8'h00);
    bus_byte(8'h31, a1, oe);
    chk("R2 no start data no ack", {7'b0, a1}, 8'h00);
    repeat (4) @(negedge clk);
    chk_out("R2 no start outputs kept", 5'b1_00_10);

    // R3 second byte ignored, R13 repeated start
    bus_start();
    bus_byte(ADDR_W, a0, oe);
    bus_byte(8'h41, a1, oe);
    bus_byte(8'h30, a1, oe);
    chk("R3 later byte ack", {7'b0, a1}, 8'h01);
    repeat (4) @(negedge clk);
    chk_out("R3 later byte ignored", 5'b1_00_01);
    bus_start();
    bus_byte(ADDR_W, a0, oe);
    chk("R13 readdress ack", {7'b0, a0}, 8'h01);
    bus_byte(8'h02, a1, oe);
    bus_stop();
    repeat (4) @(negedge clk);
    chk_out("R13 reload after repeated start", 5'b0_00_10);

    // R12 read direction
    bus_start();
    bus_byte(ADDR_R, a0, oe);
    chk("R12 read addr ack", {7'b0, a0}, 8'h01);
    bus_byte(8'hFF, a1, oe);
    chk("R12 released data bits", {7'b0, oe}, 8'h00);
    chk("R12 released ack slot", {7'b0, a1}, 8'h00);
    bus_stop();
    repeat (4) @(negedge clk);
    chk_out("R12 outputs kept", 5'b0_00_10);

    // R8 R9 auto-advance, mode 00
    write_ctrl(8'h04, a0, a1);
    pulse_done(); chk_out("R8 step to 1", 5'b0_00_01);
    pulse_done(); chk_out("R8 step to 2", 5'b0_00_10);
    pulse_done(); chk_out("R8 step to 3", 5'b0_00_11);
    pulse_done(); chk_out("R9 wrap from 3", 5'b0_00_00);
    // mode 01, channel 2 then wrap
    write_ctrl(8'h16, a0, a1);
    chk_out("R7 mode 01 ch2", 5'b0_01_10);
    pulse_done(); chk_out("R9 wrap from 2", 5'b0_01_00);
    // mode 11 clamp then wrap
    write_ctrl(8'h37, a0, a1);
    chk_out("R7 clamp mode 11", 5'b0_11_01);
    pulse_done(); chk_out("R9 wrap from 1", 5'b0_11_00);
    pulse_done(); chk_out("R8 step mode 11", 5'b0_11_01);

    // R10 no auto
    write_ctrl(8'h21, a0, a1);
    pulse_done(); pulse_done();
    chk_out("R10 no step", 5'b0_10_01);

    // R6 bit 3 is not auto-advance
    write_ctrl(8'h09, a0, a1);
    pulse_done();
    chk_out("R6 bit3 no effect", 5'b0_00_01);

    // R11 reset mid-run
    write_ctrl(8'h47, a0, a1);
    chk_out("R4 before reset", 5'b1_00_11);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_out("R11 reset clears", 5'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    done = 1;
    finish_run();
  end

endmodule